// File: doc/BRIEF.md
# AES3 Frame Encoder with Status Buffers

This block turns a stream of stereo PCM samples into a serial AES3 / S/PDIF line signal. Each frame holds a left and a right subframe. Every subframe carries a preamble, a 24-bit sample, a validity flag, a user bit, a channel-status bit and an even-parity bit. The whole subframe is biphase-mark coded onto one output wire. Frames are grouped into 192-frame blocks. The eight channel-status bits at the end of each block carry a CRC that the block computes itself.

In host mode, channel-status and user bits come from two 192-bit buffers that a host loads one byte at a time. The host writes into a shadow copy. The shadow is promoted to the active copy only at the block boundary, so a block on the line is never a mix of old and new data. In standalone mode the two bits come from input pins instead, and the buffers do not affect the line. A block-start output is high while frame 0 is on the line, so several transmitters can align their blocks.

Timing follows the master clock. One half bit cell lasts CLK_PER_FRAME/128 clock cycles, where CLK_PER_FRAME is 256, 384 or 512. A sequencer with three states drives the line:
- `ST_PRE` emits the eight preamble half-cells.
- `ST_CELL_A` is the first half of a data cell.
- `ST_CELL_B` is the second half of a data cell.

The transitions are:
- Tick `ST_PRE→ST_CELL_A` after the eighth preamble half-cell.
- Tick `ST_CELL_A→ST_CELL_B` always.
- Tick `ST_CELL_B→ST_CELL_A` while data slots remain.
- Tick `ST_CELL_B→ST_PRE` after slot 31. This transition switches to the other subframe, and after the right subframe it advances the frame, wrapping from 191 to 0.

Top module: `aes3_frame_tx`

## Requirements
- R1: Each frame sends the left subframe, then the right subframe, each with 32 slots. Slots 0-3 are the preamble. Slots 4-27 carry the sample, LSB in slot 4. Slot 28 carries `v_flag`, slot 29 the user bit, slot 30 the channel-status bit and slot 31 the parity bit.
- R2: The preamble half-cell levels, first to last, are as follows when the preceding line level is 0:
  - left subframe of frame 0: 11101000
  - left subframe of any other frame: 11100010
  - right subframe: 11100100
  
  All eight levels are inverted when the preceding line level is 1.
- R3: Each data slot takes two half-cells. The line toggles at the start of every slot and toggles again mid-slot when the slot value is 1.
- R4: The parity slot makes slots 4-31 contain an even number of ones.
- R5: One half-cell lasts CLK_PER_FRAME/128 clock cycles. The first half-cell after reset appears on the CLK_PER_FRAME/128-th rising edge after reset is released. The sample, `v_flag`, `cs_pin`, `user_pin` and `standalone` are sampled on the edge that emits a subframe's first preamble half-cell.
- R6: A write with `wr_en` high stores `wr_data` into byte `wr_byte` (0-23) of the shadow user buffer when `wr_user`=1, or of the shadow channel-status buffer when `wr_user`=0. Bit b of byte k belongs to frame 8k+b. Writes to `wr_byte` 24-31 are ignored.
- R7: In host mode, both subframes of frame f carry bit f of the active buffers. The shadow buffers are copied to the active buffers on the last half-cell of frame 191. A write therefore takes effect from the next block's frame 0 and never inside the block on the line.
- R8: In frames 184-191, both subframes carry CRC bit (f-184) in the channel-status slot, in both modes. The CRC is computed as follows:
  - It starts at 8'hFF at frame 0.
  - For frames 0-183, it is updated with the left subframe's channel-status bit d: crc = {crc[6:0],0} ^ (crc[7]^d ? 8'h1D : 0).
  - Byte 23 of the channel-status buffer is therefore never sent.
- R9: With `standalone`=1, the user and channel-status slots take `user_pin` and `cs_pin`, sampled per subframe. Buffer contents do not affect the line, although writes and swaps still proceed.
- R10: `block_start` changes together with `tx_out`. It is 1 exactly while half-cells of frame 0 are on the line.
- R11: During and after reset, `tx_out` and `block_start` are 0 and all four buffers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, CLK_PER_FRAME times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| standalone | input | 1 | 1: status and user bits from pins; 0: from buffers |
| left_pcm | input | 24 | Left sample |
| right_pcm | input | 24 | Right sample |
| v_flag | input | 1 | Validity slot value |
| cs_pin | input | 1 | Channel-status bit in standalone mode |
| user_pin | input | 1 | User bit in standalone mode |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_user | input | 1 | 1: user buffer; 0: channel-status buffer |
| wr_byte | input | 5 | Byte index within the block |
| wr_data | input | 8 | Byte to write |
| tx_out | output | 1 | Biphase-mark coded line output |
| block_start | output | 1 | High during frame 0 |

## Verification
A wrong count in the slot, preamble or frame counters shifts every later half-cell. A reference model that predicts each line level shows such a fault on `tx_out` within one half-cell of the slip. A bad parity or data bit breaks the return to the subframe's starting line level within the same subframe. A fault in the CRC register or in the buffer swap stays hidden until the channel-status slots of the affected frames are on the line: for the CRC that is frame 184 of the block, and for the swap it is the frame whose bit changed, in the following block. The bench therefore runs across two block boundaries and loads new bytes in the middle of a block.

// File: rtl/aes_tx_pkg.sv
package aes_tx_pkg;
    localparam int SAMPLE_W         = 24;
    localparam int DATA_SLOTS       = 28;
    localparam int FIRST_DATA_SLOT  = 4;
    localparam int LAST_SLOT        = 31;
    localparam int SLOT_W           = 5;
    localparam int PRE_HALVES       = 8;
    localparam int PRE_W            = $clog2(PRE_HALVES);
    localparam int HALVES_PER_FRAME = 128;
    localparam int FRAMES_PER_BLOCK = 192;
    localparam int FIDX_W           = $clog2(FRAMES_PER_BLOCK);
    localparam int BLOCK_BYTES      = FRAMES_PER_BLOCK / 8;
    localparam int BYTE_AW          = $clog2(BLOCK_BYTES);
    localparam int CRC_W            = 8;
    localparam int CRC_START        = FRAMES_PER_BLOCK - CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;

    // Half-cell levels, first half-cell in bit 7, for a preceding level of 0.
    localparam logic [PRE_HALVES-1:0] PAT_BLOCK = 8'hE8;
    localparam logic [PRE_HALVES-1:0] PAT_LEFT  = 8'hE2;
    localparam logic [PRE_HALVES-1:0] PAT_RIGHT = 8'hE4;

    typedef enum logic [1:0] {
        ST_PRE    = 2'd0,
        ST_CELL_A = 2'd1,
        ST_CELL_B = 2'd2
    } tx_state_e;
endpackage

// File: rtl/aes_cu_store.sv
module aes_cu_store
    import aes_tx_pkg::*;
#(
    parameter int DEPTH = FRAMES_PER_BLOCK
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           wr_user,
    input  logic [BYTE_AW-1:0]             wr_byte,
    input  logic [7:0]                     wr_data,
    input  logic                           swap,
    input  logic [$clog2(DEPTH)-1:0]       rd_frame,
    output logic                           cs_bit,
    output logic                           u_bit
);
    localparam int NBYTES = DEPTH / 8;
    localparam int IW     = $clog2(DEPTH);
    localparam int NBUF   = 2;   // index 0: channel status, 1: user

    logic [IW-1:0]   base;
    logic            in_range;
    logic [NBUF-1:0] rd_bits;

    assign in_range = (int'(wr_byte) < NBYTES);
    assign base     = IW'({wr_byte, 3'b000});

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic [DEPTH-1:0] shadow_q;
        logic [DEPTH-1:0] active_q;
        logic             sel;

        assign sel = (g == 1) ? wr_user : ~wr_user;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
                active_q <= '0;
            end else begin
                if (swap)
                    active_q <= shadow_q;
                if (wr_en && sel && in_range)
                    shadow_q[base +: 8] <= wr_data;
            end
        end

        assign rd_bits[g] = active_q[rd_frame];
    end

    assign cs_bit = rd_bits[0];
    assign u_bit  = rd_bits[1];
endmodule

// File: rtl/aes_cs_crc.sv
module aes_cs_crc
    import aes_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q
);
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] nxt;

    always_comb begin
        seed = restart ? '1 : crc_q;
        nxt  = {seed[CRC_W-2:0], 1'b0} ^ ((seed[CRC_W-1] ^ din) ? CRC_POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_q <= '1;
        else if (step)    crc_q <= nxt;
        else if (restart) crc_q <= '1;
    end
endmodule

// File: rtl/aes_subframe_pack.sv
module aes_subframe_pack
    import aes_tx_pkg::*;
(
    input  logic [SAMPLE_W-1:0]   pcm,
    input  logic                  v_bit,
    input  logic                  u_bit,
    input  logic                  c_bit,
    output logic [DATA_SLOTS-1:0] word
);
    logic [DATA_SLOTS-2:0] body;

    assign body = {c_bit, u_bit, v_bit, pcm};
    assign word = {^body, body};
endmodule

// File: rtl/aes3_frame_tx.sv
module aes3_frame_tx
    import aes_tx_pkg::*;
#(
    parameter int CLK_PER_FRAME = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                standalone,
    input  logic [SAMPLE_W-1:0] left_pcm,
    input  logic [SAMPLE_W-1:0] right_pcm,
    input  logic                v_flag,
    input  logic                cs_pin,
    input  logic                user_pin,
    input  logic                wr_en,
    input  logic                wr_user,
    input  logic [BYTE_AW-1:0]  wr_byte,
    input  logic [7:0]          wr_data,
    output logic                tx_out,
    output logic                block_start
);
    localparam int DIV   = CLK_PER_FRAME / HALVES_PER_FRAME;
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(FRAMES_PER_BLOCK - 1);
    localparam logic [SLOT_W-1:0] SLOT_END   = SLOT_W'(LAST_SLOT);
    localparam logic [SLOT_W-1:0] SLOT_BEGIN = SLOT_W'(FIRST_DATA_SLOT);
    localparam logic [PRE_W-1:0]  PRE_END    = PRE_W'(PRE_HALVES - 1);

    // Half-cell tick
    logic tick;
    if (DIV == 1) begin : g_nodiv
        assign tick = 1'b1;
    end else begin : g_div
        logic [DIV_W-1:0] div_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         div_q <= '0;
            else if (div_q == DIV_W'(DIV - 1))  div_q <= '0;
            else                                div_q <= div_q + 1'b1;
        end
        assign tick = (div_q == DIV_W'(DIV - 1));
    end

    // Sequencer state
    tx_state_e          state_q, state_d;
    logic [PRE_W-1:0]   pre_q,   pre_d;
    logic [SLOT_W-1:0]  slot_q,  slot_d;
    logic               right_q, right_d;
    logic [FIDX_W-1:0]  frame_q, frame_d;

    // Output-side registers
    logic                  tx_q, tx_d;
    logic                  ref_q, ref_d;
    logic                  blk_q, blk_d;
    logic [DATA_SLOTS-1:0] shift_q, shift_d;

    // Datapath
    logic                  load, swap, crc_zone;
    logic                  buf_cs, buf_u, c_src, u_src, c_eff;
    logic [CRC_W-1:0]      crc_q;
    logic [DATA_SLOTS-1:0] word;
    logic [PRE_HALVES-1:0] pat;

    assign load     = tick && (state_q == ST_PRE) && (pre_q == '0);
    assign swap     = tick && (state_q == ST_CELL_B) && (slot_q == SLOT_END)
                      && right_q && (frame_q == LAST_FRAME);
    assign crc_zone = (frame_q >= FIDX_W'(CRC_START));
    assign c_src    = standalone ? cs_pin   : buf_cs;
    assign u_src    = standalone ? user_pin : buf_u;
    assign c_eff    = crc_zone ? crc_q[3'(frame_q - FIDX_W'(CRC_START))] : c_src;
    assign pat      = right_q ? PAT_RIGHT : ((frame_q == '0) ? PAT_BLOCK : PAT_LEFT);

    aes_cu_store #(.DEPTH(FRAMES_PER_BLOCK)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_user  (wr_user),
        .wr_byte  (wr_byte),
        .wr_data  (wr_data),
        .swap     (swap),
        .rd_frame (frame_q),
        .cs_bit   (buf_cs),
        .u_bit    (buf_u)
    );

    aes_cs_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load && !right_q && (frame_q == '0)),
        .step    (load && !right_q && !crc_zone),
        .din     (c_src),
        .crc_q   (crc_q)
    );

    aes_subframe_pack u_pack (
        .pcm   (right_q ? right_pcm : left_pcm),
        .v_bit (v_flag),
        .u_bit (u_src),
        .c_bit (c_eff),
        .word  (word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pre_d   = pre_q;
        slot_d  = slot_q;
        right_d = right_q;
        frame_d = frame_q;
        if (tick) begin
            unique case (state_q)
                ST_PRE: begin
                    if (pre_q == PRE_END) begin
                        state_d = ST_CELL_A;
                        slot_d  = SLOT_BEGIN;
                    end else begin
                        pre_d = pre_q + 1'b1;
                    end
                end
                ST_CELL_A: state_d = ST_CELL_B;
                ST_CELL_B: begin
                    if (slot_q == SLOT_END) begin
                        state_d = ST_PRE;
                        pre_d   = '0;
                        right_d = ~right_q;
                        if (right_q)
                            frame_d = (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
                    end else begin
                        state_d = ST_CELL_A;
                        slot_d  = slot_q + 1'b1;
                    end
                end
                default: state_d = ST_PRE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRE;
            pre_q   <= '0;
            slot_q  <= SLOT_BEGIN;
            right_q <= 1'b0;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
            slot_q  <= slot_d;
            right_q <= right_d;
            frame_q <= frame_d;
        end
    end

    // Output logic
    always_comb begin
        tx_d    = tx_q;
        ref_d   = ref_q;
        blk_d   = blk_q;
        shift_d = shift_q;
        if (tick) begin
            blk_d = (frame_q == '0);
            unique case (state_q)
                ST_PRE: begin
                    if (pre_q == '0) begin
                        ref_d   = tx_q;
                        shift_d = word;
                        tx_d    = pat[PRE_HALVES-1] ^ tx_q;
                    end else begin
                        tx_d = pat[PRE_END - pre_q] ^ ref_q;
                    end
                end
                ST_CELL_A: tx_d = ~tx_q;
                ST_CELL_B: begin
                    tx_d    = tx_q ^ shift_q[0];
                    shift_d = shift_q >> 1;
                end
                default: tx_d = tx_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= 1'b0;
            ref_q   <= 1'b0;
            blk_q   <= 1'b0;
            shift_q <= '0;
        end else begin
            tx_q    <= tx_d;
            ref_q   <= ref_d;
            blk_q   <= blk_d;
            shift_q <= shift_d;
        end
    end

    assign tx_out      = tx_q;
    assign block_start = blk_q;
endmodule

// File: rtl/aes3_frame_tx_chk.sv
module aes3_frame_tx_chk
    import aes_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input tx_state_e         state_q,
    input logic [PRE_W-1:0]  pre_q,
    input logic [SLOT_W-1:0] slot_q,
    input logic [FIDX_W-1:0] frame_q,
    input logic              ref_q,
    input logic              tx_out,
    input logic              block_start
);
    // R3: every data cell starts with a line transition
    a_r3_cell_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == ST_CELL_A) |=> (tx_out != $past(tx_out)));

    // R4: even parity returns the line to its level before the preamble
    a_r4_even_return: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == ST_CELL_B && slot_q == SLOT_W'(LAST_SLOT))
        |=> (tx_out == $past(ref_q)));

    // R1: the preamble is exactly eight half-cells, then data slot 4
    a_r1_preamble_len: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == ST_PRE && pre_q == PRE_W'(PRE_HALVES - 1))
        |=> (state_q == ST_CELL_A && slot_q == SLOT_W'(FIRST_DATA_SLOT)));

    // R10: block_start only rises while frame 0 is on the line
    a_r10_block_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block_start) |-> ($past(frame_q) == '0 && $past(tick)));

    // R7: the frame index stays inside one block
    a_r7_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(frame_q) < FRAMES_PER_BLOCK));
endmodule

bind aes3_frame_tx aes3_frame_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .state_q     (state_q),
    .pre_q       (pre_q),
    .slot_q      (slot_q),
    .frame_q     (frame_q),
    .ref_q       (ref_q),
    .tx_out      (tx_out),
    .block_start (block_start)
);

// File: tb/aes3_frame_tx_bench.sv
`timescale 1ns/1ps
module aes3_frame_tx_bench;
    import aes_tx_pkg::*;

    localparam int CPF   = 256;
    localparam int DIV   = CPF / 128;
    localparam int BLOCK = 192 * CPF;

    logic        clk = 1'b0, rst_n = 1'b0, standalone = 1'b0;
    logic        v_flag = 1'b0, cs_pin = 1'b0, user_pin = 1'b0;
    logic        wr_en = 1'b0, wr_user = 1'b0;
    logic [23:0] left_pcm = '0, right_pcm = '0;
    logic [4:0]  wr_byte = '0;
    logic [7:0]  wr_data = '0;
    logic        tx_out, block_start;

    int checks = 0, failures = 0;
    int pat_mode = 0;
    bit run_cmp = 1'b0;

    always #2.5 clk = ~clk;

    aes3_frame_tx #(.CLK_PER_FRAME(CPF)) u_aes3_frame_tx (
        .clk(clk), .rst_n(rst_n), .standalone(standalone),
        .left_pcm(left_pcm), .right_pcm(right_pcm), .v_flag(v_flag),
        .cs_pin(cs_pin), .user_pin(user_pin),
        .wr_en(wr_en), .wr_user(wr_user), .wr_byte(wr_byte), .wr_data(wr_data),
        .tx_out(tx_out), .block_start(block_start)
    );

    // ---------------- reference model ----------------
    bit    m_cs_sh[192], m_cs_act[192], m_u_sh[192], m_u_act[192];
    bit    lvl_q[$];
    string tag_q[$];
    int    m_edges, m_frame, q_frame;
    bit    m_right, q_right, m_line, m_first, tick_now;
    bit [7:0] m_crc;
    bit    exp_tx, exp_blk;
    string exp_tag = "R11";

    task automatic build_subframe();
        bit [27:0] w;
        bit [23:0] s;
        bit [7:0]  p;
        bit c, u, lv;
        string ct, ut;
        q_frame = m_frame;
        q_right = m_right;
        if (m_frame >= 184) c = m_crc[m_frame - 184];
        else                c = standalone ? cs_pin : m_cs_act[m_frame];
        u  = standalone ? user_pin : m_u_act[m_frame];
        ct = (m_frame >= 184) ? "R8" : (standalone ? "R9" : "R7");
        ut = standalone ? "R9" : "R6";
        if (!m_right && m_frame < 184) begin
            if (m_frame == 0) m_crc = 8'hFF;
            m_crc = (m_crc << 1) ^ ((m_crc[7] ^ c) ? 8'h1D : 8'h00);
        end
        s = m_right ? right_pcm : left_pcm;
        w[23:0] = s;
        w[24] = v_flag;
        w[25] = u;
        w[26] = c;
        w[27] = ^{c, u, v_flag, s};
        p = m_right ? 8'hE4 : ((m_frame == 0) ? 8'hE8 : 8'hE2);
        for (int i = 0; i < 8; i++) begin
            lvl_q.push_back(p[7 - i] ^ m_line);
            tag_q.push_back((m_first && i == 0) ? "R5" : "R2");
        end
        m_first = 1'b0;
        lv = m_line;
        for (int i = 0; i < 28; i++) begin
            lv = ~lv;
            lvl_q.push_back(lv);
            tag_q.push_back("R3");
            if (w[i]) lv = ~lv;
            lvl_q.push_back(lv);
            if (i < 25)       tag_q.push_back("R1");
            else if (i == 25) tag_q.push_back(ut);
            else if (i == 26) tag_q.push_back(ct);
            else              tag_q.push_back("R4");
        end
        m_line = lv;
        if (m_right) m_frame = (m_frame + 1) % 192;
        m_right = ~m_right;
    endtask

    initial forever begin
        @(posedge clk);
        if (!rst_n) begin
            m_edges = 0; m_frame = 0; m_right = 0; m_line = 0; m_first = 1;
            m_crc = 8'hFF; exp_tx = 0; exp_blk = 0;
            lvl_q.delete(); tag_q.delete();
            foreach (m_cs_sh[i]) begin
                m_cs_sh[i] = 0; m_cs_act[i] = 0; m_u_sh[i] = 0; m_u_act[i] = 0;
            end
        end else begin
            tick_now = ((m_edges % DIV) == DIV - 1);
            m_edges++;
            if (tick_now) begin
                if (lvl_q.size() == 0) build_subframe();
                exp_tx  = lvl_q.pop_front();
                exp_tag = tag_q.pop_front();
                exp_blk = (q_frame == 0);
                if (lvl_q.size() == 0 && q_right && q_frame == 191) begin
                    m_cs_act = m_cs_sh;
                    m_u_act  = m_u_sh;
                end
            end
            if (wr_en && int'(wr_byte) < 24) begin
                for (int k = 0; k < 8; k++) begin
                    if (wr_user) m_u_sh[wr_byte * 8 + k]  = wr_data[k];
                    else         m_cs_sh[wr_byte * 8 + k] = wr_data[k];
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (rst_n && run_cmp) begin
            check(tx_out, exp_tx, exp_tag);
            check(block_start, exp_blk, "R10");
        end
    end

    // ---------------- stimulus ----------------
    initial forever begin
        @(negedge clk);
        case (pat_mode)
            0: begin left_pcm = 24'($urandom); right_pcm = 24'($urandom); end
            1: begin left_pcm = '1; right_pcm = '1; end
            2: begin left_pcm = '0; right_pcm = '0; end
            default: begin left_pcm = 24'hAAAAAA; right_pcm = 24'h555555; end
        endcase
        v_flag   = 1'($urandom);
        cs_pin   = 1'($urandom);
        user_pin = 1'($urandom);
    end

    task automatic host_write(input bit usr, input int idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_user = usr; wr_byte = 5'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(tx_out, 1'b0, "R11");
        check(block_start, 1'b0, "R11");
        rst_n = 1'b1;
        run_cmp = 1'b1;
        // R11: block 0 runs on cleared buffers; R6: load shadow buffers
        repeat (5 * CPF) @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            host_write(1'b0, i, 8'(i * 37 + 5));
            host_write(1'b1, i, 8'(~(i * 11)));
        end
        host_write(1'b0, 23, 8'hAA);      // R8: byte replaced by CRC
        host_write(1'b0, 27, 8'hFF);      // R6: ignored address
        host_write(1'b1, 30, 8'hFF);      // R6: ignored address
        pat_mode = 1;
        repeat (40 * CPF) @(negedge clk);
        pat_mode = 2;
        repeat (40 * CPF) @(negedge clk);
        pat_mode = 3;
        repeat (BLOCK - 90 * CPF) @(negedge clk);
        // block 1: R7 mid-block writes wait for the next block
        pat_mode = 0;
        repeat (50 * CPF) @(negedge clk);
        host_write(1'b0, 3, 8'h5A);
        host_write(1'b1, 0, 8'hC3);
        repeat (BLOCK - 50 * CPF) @(negedge clk);
        // block 2: R9 standalone pins
        standalone = 1'b1;
        repeat (20 * CPF) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule